// File: doc/BRIEF.md
# Activity-Switched Console Serial Multiplexer

This block connects two host-side serial channels to a set of five external console endpoints: a serial-over-LAN stream, a front RJ45 jack, a front mini-USB bridge, a rear-module mini-USB and a rear-module RJ45. Each endpoint is a plain transmit/receive bit pair. Each host channel has a selection register. A fixed code ties the channel to one endpoint or leaves it open. An automatic code lets the channel follow whichever console most recently began typing.

Receive lines pass through two-flop synchronizers and then through a low-time filter. The filter turns a falling edge that stays low long enough into a single activity event. In automatic mode an event on an endpoint that the channel does not own makes that endpoint the pending owner. The hand-off completes only while the host transmit line is high, so an outgoing character is not cut. Any endpoint output that is not connected is held at mark level (high).

Channel 0 outranks channel 1. If both channels point at the same endpoint, only channel 0 is connected to it.

Top module: `uart_console_mux`

## Requirements
- R1: After reset, channel 0 reports owner code 3 (front mini-USB). Channel 1 also selects code 3, but it is masked by priority and reports 0. Automatic mode is off on both channels, both error flags are low and every endpoint transmit line is high.
- R2: Code 0 leaves a channel open. Its reported owner is 0 and its host receive line stays at 1 whatever the endpoints do.
- R3: Manual codes 1 to 5 map in order to endpoint bits 0 to 4: serial-over-LAN, front RJ45, front mini-USB, rear mini-USB, rear RJ45. With code c, ep_tx[c-1] follows the channel's host_tx in the same cycle. The channel's host_rx follows ep_rx[c-1] with a two-cycle delay. The owner does not change without a write.
- R4: An endpoint that no channel owns drives ep_tx high. When a channel moves away from an endpoint, that endpoint's receive line no longer reaches the channel's host_rx.
- R5: If channel 1's selection equals channel 0's nonzero owner, channel 1 reports owner 0 and is not connected to any endpoint.
- R6: Writing 0x0F turns on automatic mode and keeps the current owner. A receive line that is held low for at least the window count of cycles, on an endpoint the channel does not own, moves ownership to that endpoint.
- R7: A low pulse shorter than the window count does not move ownership.
- R8: In automatic mode, an ownership move waits while the channel's host_tx is low. It completes within two cycles after host_tx returns high.
- R9: Writing a code other than 0 to 5 or 0x0F leaves the selection and the mode unchanged. It sets that channel's error flag, and the flag stays set until reset.
- R10: When channel 0 is in automatic mode, every activity event goes to channel 0. When channel 1 is in automatic mode and channel 0 is not, channel 1 ignores activity on channel 0's endpoint.
- R11: Register address 2 sets the window count, in clock cycles, used by the activity filter (reset value 8). Address 0 holds channel 0's selection and address 1 holds channel 1's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0: channel 0 select, 1: channel 1 select, 2: activity window |
| reg_wdata | input | 8 | Write data |
| host_tx | input | 2 | Transmit line from each host channel |
| host_rx | output | 2 | Receive line to each host channel |
| ep_rx | input | 5 | Receive lines from the endpoints |
| ep_tx | output | 5 | Transmit lines to the endpoints |
| owner_code | output | 8 | Effective owner code per channel, 4 bits each, channel 0 in the low nibble |
| auto_mode | output | 2 | Automatic mode flag per channel |
| sel_err | output | 2 | Sticky unsupported-code flag per channel |

## Verification
A corrupt selection register shows at once on owner_code. It also shows in the same cycle on ep_tx, where a wrong endpoint follows host_tx or the intended one stays high. A broken synchronizer path or a wrong mux index shows on host_rx within three cycles of an ep_rx change. A filter counter that is off by even one cycle shows up when a pulse just shorter than the window moves ownership. A hand-off that ignores host_tx shows up when owner_code changes while host_tx is held low. Priority faults show when a channel 1 owner code matches channel 0's.

// File: rtl/ucm_pkg.sv
package ucm_pkg;
    localparam int EP_N   = 5;
    localparam int CH_N   = 2;
    localparam int CODE_W = 4;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_OPEN = 4'd0;
    localparam code_t CODE_FUSB = 4'd3;
    localparam logic [7:0] WR_AUTO = 8'h0F;

    typedef enum logic [1:0] {
        RA_SEL0 = 2'd0,
        RA_SEL1 = 2'd1,
        RA_WIN  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        code_t sel;
        logic  auto_on;
        logic  err;
    } chan_state_t;

    typedef struct packed {
        logic  valid;
        code_t code;
    } pend_t;

    function automatic logic is_manual(input logic [7:0] w);
        return w <= 8'(EP_N);
    endfunction

    function automatic logic [EP_N-1:0] code_mask(input code_t c);
        logic [EP_N-1:0] m;
        m = '0;
        for (int e = 0; e < EP_N; e++) begin
            if (c == code_t'(e + 1)) m[e] = 1'b1;
        end
        return m;
    endfunction

    function automatic code_t first_code(input logic [EP_N-1:0] v);
        code_t c;
        c = CODE_OPEN;
        for (int e = EP_N - 1; e >= 0; e--) begin
            if (v[e]) c = code_t'(e + 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/ucm_act_det.sv
module ucm_act_det #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_in,
    input  logic [CNT_W-1:0] win,
    output logic             rx_sync,
    output logic             act
);
    logic             s1_q, s2_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;
    logic [CNT_W:0]   cnt_nx;

    assign cnt_nx  = {1'b0, cnt_q} + 1'b1;
    assign rx_sync = s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            cnt_q   <= '0;
            fired_q <= 1'b0;
            act     <= 1'b0;
        end else begin
            s1_q <= rx_in;
            s2_q <= s1_q;
            act  <= 1'b0;
            if (s2_q) begin
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else if (!fired_q) begin
                if (cnt_nx >= {1'b0, win}) begin
                    act     <= 1'b1;
                    fired_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_nx[CNT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/ucm_chan_ctl.sv
module ucm_chan_ctl
    import ucm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [7:0]      wdata,
    input  logic [EP_N-1:0] act,
    input  logic            host_idle,
    output code_t           sel,
    output logic            auto_on,
    output logic            err
);
    chan_state_t     st_q, st_d;
    pend_t           pend_q, pend_d;
    logic [EP_N-1:0] fresh;

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        fresh  = act & ~code_mask(st_q.sel);
        if (wr_en) begin
            if (is_manual(wdata)) begin
                st_d.sel     = code_t'(wdata[CODE_W-1:0]);
                st_d.auto_on = 1'b0;
                pend_d       = '0;
            end else if (wdata == WR_AUTO) begin
                st_d.auto_on = 1'b1;
                pend_d       = '0;
            end else begin
                st_d.err = 1'b1;
            end
        end else if (st_q.auto_on) begin
            if (|fresh) begin
                pend_d.valid = 1'b1;
                pend_d.code  = first_code(fresh);
            end
            if (pend_d.valid && host_idle) begin
                st_d.sel     = pend_d.code;
                pend_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sel     <= CODE_FUSB;
            st_q.auto_on <= 1'b0;
            st_q.err     <= 1'b0;
            pend_q       <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    assign sel     = st_q.sel;
    assign auto_on = st_q.auto_on;
    assign err     = st_q.err;
endmodule

// File: rtl/ucm_xbar.sv
module ucm_xbar
    import ucm_pkg::*;
(
    input  code_t           eff0,
    input  code_t           eff1,
    input  logic [CH_N-1:0] host_tx,
    input  logic [EP_N-1:0] rx_sync,
    output logic [CH_N-1:0] host_rx,
    output logic [EP_N-1:0] ep_tx
);
    logic [EP_N-1:0] m0, m1;

    assign m0 = code_mask(eff0);
    assign m1 = code_mask(eff1);

    generate
        for (genvar e = 0; e < EP_N; e++) begin : g_ep
            always_comb begin
                if (m0[e])      ep_tx[e] = host_tx[0];
                else if (m1[e]) ep_tx[e] = host_tx[1];
                else            ep_tx[e] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        host_rx[0] = (|m0) ? |(rx_sync & m0) : 1'b1;
        host_rx[1] = (|m1) ? |(rx_sync & m1) : 1'b1;
    end
endmodule

// File: rtl/uart_console_mux.sv
module uart_console_mux
    import ucm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DEF_WIN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic [1:0]           host_tx,
    output logic [1:0]           host_rx,
    input  logic [4:0]           ep_rx,
    output logic [4:0]           ep_tx,
    output logic [7:0]           owner_code,
    output logic [1:0]           auto_mode,
    output logic [1:0]           sel_err
);
    logic [CNT_W-1:0] win_q;
    logic [EP_N-1:0]  rx_sync, act;
    logic [EP_N-1:0]  act_ch [CH_N];
    code_t            sel    [CH_N];
    code_t            eff0, eff1;
    logic [CH_N-1:0]  auto_v, err_v, wr_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= CNT_W'(DEF_WIN);
        end else if (reg_we && reg_addr == RA_WIN) begin
            win_q <= CNT_W'(reg_wdata);
        end
    end

    generate
        for (genvar e = 0; e < EP_N; e++) begin : g_det
            ucm_act_det #(.CNT_W(CNT_W)) u_det (
                .clk     (clk),
                .rst     (rst),
                .rx_in   (ep_rx[e]),
                .win     (win_q),
                .rx_sync (rx_sync[e]),
                .act     (act[e])
            );
        end
    endgenerate

    assign eff0 = sel[0];
    assign eff1 = (sel[1] == sel[0] && sel[1] != CODE_OPEN) ? CODE_OPEN : sel[1];

    assign act_ch[0] = act & {EP_N{auto_v[0]}};
    assign act_ch[1] = act & {EP_N{auto_v[1] & ~auto_v[0]}} & ~code_mask(eff0);

    assign wr_ch[0] = reg_we && reg_addr == RA_SEL0;
    assign wr_ch[1] = reg_we && reg_addr == RA_SEL1;

    generate
        for (genvar c = 0; c < CH_N; c++) begin : g_ch
            ucm_chan_ctl u_ctl (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (wr_ch[c]),
                .wdata     (reg_wdata),
                .act       (act_ch[c]),
                .host_idle (host_tx[c]),
                .sel       (sel[c]),
                .auto_on   (auto_v[c]),
                .err       (err_v[c])
            );
        end
    endgenerate

    ucm_xbar u_xbar (
        .eff0    (eff0),
        .eff1    (eff1),
        .host_tx (host_tx),
        .rx_sync (rx_sync),
        .host_rx (host_rx),
        .ep_tx   (ep_tx)
    );

    assign owner_code = {eff1, eff0};
    assign auto_mode  = auto_v;
    assign sel_err    = err_v;
endmodule

// File: rtl/uart_console_mux_chk.sv
module uart_console_mux_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic [1:0] host_tx,
    input logic [1:0] host_rx,
    input logic [4:0] ep_tx,
    input logic [7:0] owner_code,
    input logic [1:0] auto_mode,
    input logic [1:0] sel_err
);
    logic [4:0] owned;
    always_comb begin
        owned = '0;
        for (int e = 0; e < 5; e++) begin
            if (owner_code[3:0] == 4'(e + 1) || owner_code[7:4] == 4'(e + 1)) owned[e] = 1'b1;
        end
    end

    p_idle_unowned_r4: assert property (@(posedge clk) disable iff (rst)
        ((ep_tx | owned) == 5'h1F));

    p_prio_r5: assert property (@(posedge clk) disable iff (rst)
        (owner_code[7:4] != 4'd0) |-> (owner_code[7:4] != owner_code[3:0]));

    p_open_rx_r2: assert property (@(posedge clk) disable iff (rst)
        (owner_code[3:0] == 4'd0) |-> host_rx[0]);

    p_code_range_r3: assert property (@(posedge clk) disable iff (rst)
        (owner_code[3:0] <= 4'd5) && (owner_code[7:4] <= 4'd5));

    p_manual_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!auto_mode[0] && !(reg_we && reg_addr == 2'd0)) |=> $stable(owner_code[3:0]));

    p_defer_r8: assert property (@(posedge clk) disable iff (rst)
        (auto_mode[0] && !host_tx[0] && !(reg_we && reg_addr == 2'd0)) |=> $stable(owner_code[3:0]));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        sel_err[0] |=> sel_err[0]);
endmodule

bind uart_console_mux uart_console_mux_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .host_tx    (host_tx),
    .host_rx    (host_rx),
    .ep_tx      (ep_tx),
    .owner_code (owner_code),
    .auto_mode  (auto_mode),
    .sel_err    (sel_err)
);

// File: tb/sim_uart_console_mux.sv
module sim_uart_console_mux;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] host_tx = 2'b11;
    logic [1:0] host_rx;
    logic [4:0] ep_rx = 5'h1F;
    logic [4:0] ep_tx;
    logic [7:0] owner_code;
    logic [1:0] auto_mode;
    logic [1:0] sel_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_console_mux u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .host_tx(host_tx), .host_rx(host_rx),
        .ep_rx(ep_rx), .ep_tx(ep_tx), .owner_code(owner_code),
        .auto_mode(auto_mode), .sel_err(sel_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input int e, input int len);
        @(negedge clk);
        ep_rx[e] = 1'b0;
        repeat (len) @(negedge clk);
        ep_rx[e] = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 owner", owner_code, 8'h03);
        chk("R1 auto", auto_mode, 0);
        chk("R1 err", sel_err, 0);
        chk("R1 ep_tx", ep_tx, 5'h1F);

        // R2 R3 R4 sweep of manual codes on channel 0
        wr(2'd1, 8'h00);
        for (int c = 0; c <= 5; c++) begin
            wr(2'd0, 8'(c));
            chk("R3 owner", owner_code[3:0], c);
            for (int h = 0; h < 2; h++) begin
                host_tx[0] = 1'(h);
                @(negedge clk);
                for (int e = 0; e < 5; e++)
                    chk("R3 R4 ep_tx", ep_tx[e], (e == c - 1) ? h : 1);
            end
            host_tx[0] = 1'b1;
            for (int p = 0; p < 32; p++) begin
                ep_rx = 5'(p);
                repeat (3) @(negedge clk);
                chk("R3 R2 host_rx0", host_rx[0], (c == 0) ? 1 : ((p >> (c - 1)) & 1));
                chk("R2 host_rx1 open", host_rx[1], 1);
            end
            ep_rx = 5'h1F;
            repeat (12) @(negedge clk);
        end

        // R5 priority sweep
        for (int a = 0; a <= 5; a++) begin
            for (int b = 0; b <= 5; b++) begin
                wr(2'd0, 8'(a));
                wr(2'd1, 8'(b));
                chk("R5 ch0", owner_code[3:0], a);
                chk("R5 ch1", owner_code[7:4], (a == b && b != 0) ? 0 : b);
            end
        end

        // R6 R7 R8 automatic mode on channel 0
        wr(2'd1, 8'h00);
        wr(2'd2, 8'd4);
        wr(2'd0, 8'd2);
        wr(2'd0, 8'h0F);
        chk("R6 auto on", auto_mode[0], 1);
        chk("R6 owner kept", owner_code[3:0], 2);
        pulse(4, 6);
        chk("R6 moved", owner_code[3:0], 5);
        host_tx[0] = 1'b0;
        @(negedge clk);
        chk("R4 new ep follows", ep_tx[4], 0);
        chk("R4 old ep idle", ep_tx[1], 1);
        host_tx[0] = 1'b1;
        @(negedge clk);
        ep_rx[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 old rx ignored", host_rx[0], 1);
        ep_rx[1] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R7 short low kept", owner_code[3:0], 5);
        pulse(0, 2);
        chk("R7 glitch", owner_code[3:0], 5);
        host_tx[0] = 1'b0;
        pulse(1, 6);
        chk("R8 deferred", owner_code[3:0], 5);
        host_tx[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 completes", owner_code[3:0], 2);

        // R11 window register
        wr(2'd2, 8'd10);
        pulse(4, 8);
        chk("R11 below window", owner_code[3:0], 2);
        pulse(4, 12);
        chk("R11 above window", owner_code[3:0], 5);
        wr(2'd2, 8'd4);

        // R9 unsupported codes
        wr(2'd0, 8'h07);
        chk("R9 owner kept", owner_code[3:0], 5);
        chk("R9 auto kept", auto_mode[0], 1);
        chk("R9 err0", sel_err[0], 1);
        chk("R9 err1 clear", sel_err[1], 0);
        wr(2'd0, 8'h02);
        chk("R9 sticky", sel_err[0], 1);
        wr(2'd1, 8'hFF);
        chk("R9 err1", sel_err[1], 1);
        chk("R9 ch1 owner kept", owner_code[7:4], 0);

        // R10 channel 1 automatic mode with priority
        wr(2'd0, 8'd1);
        wr(2'd1, 8'h0F);
        pulse(0, 6);
        chk("R10 ch1 ignores ch0 ep", owner_code[7:4], 0);
        pulse(3, 6);
        chk("R10 ch1 takes", owner_code[7:4], 4);
        wr(2'd0, 8'h0F);
        pulse(2, 6);
        chk("R10 ch0 takes", owner_code[3:0], 3);
        chk("R10 ch1 unchanged", owner_code[7:4], 4);
        pulse(3, 6);
        chk("R10 ch0 steals", owner_code[3:0], 4);
        chk("R5 ch1 masked", owner_code[7:4], 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule